// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block moves data words from a write clock domain to an independent read clock domain through a circular storage array. Each side keeps its own binary pointer. Each pointer crosses into the opposite domain as Gray code through a chain of flip-flop synchronizers. Because the other side's pointer always arrives late, each side sees a fill level that errs on the safe side.

Two active-low threshold flags report how full the FIFO is. The near-full flag lives in the write clock domain and goes low when the fill level comes within `m` words of the maximum depth. The near-empty flag lives in the read clock domain and goes low when the fill level is at or below `n` words. The offsets come from parameters, or from input pins when the load pin is high during master reset.

A mode pin is captured during master reset and selects one of two read modes:
- **Request mode:** `rd_ready` is a read request, and the word appears one read clock later with a single-cycle `rd_valid`.
- **Look-ahead mode:** the oldest word is presented on `rd_data` with `rd_valid` high and waits there. It is consumed when `rd_ready` is high at a read clock edge. The output register counts as one extra word of storage.

Write side back-pressure: `wr_ready` is high exactly when a word can be accepted. A word is taken on a write clock edge where `wr_valid` and `wr_ready` are both high. `wr_valid` may rise without waiting for `wr_ready`.

Top module: `dcfifo_pflag`

## Requirements
- R1: While `rst_n` is low, and after its release with no traffic, the FIFO is empty: `wr_ready`=1, `rd_valid`=0, `almost_empty_n`=0, `almost_full_n`=1.
- R2: In request mode (mode pin 0 at reset), a `rd_ready` high at a read clock edge while data is stored gives `rd_valid`=1 during the next read clock cycle. `rd_data` then carries the oldest word, and words leave in write order. With `rd_ready` low, `rd_valid` is 0 one cycle later.
- R3: In look-ahead mode (mode pin 1 at reset), the oldest stored word appears on `rd_data` with `rd_valid`=1 without any request. It stays unchanged until an edge with `rd_ready`=1 consumes it.
- R4: The maximum depth D is 2^ADDR_W words in request mode and 2^ADDR_W+1 in look-ahead mode. `wr_ready` stays 1 until D words are held, then drops to 0.
- R5: A write attempted while `wr_ready`=0 is ignored. Draining a full FIFO returns exactly D words, with none of the rejected data among them.
- R6: A read attempted while the FIFO is empty is ignored. No word is produced, and the next word written is the next word read.
- R7: `almost_full_n` changes only on write clock edges. It is 0 when the fill level is D−m or more. It returns to 1 within a few write clock cycles of the level falling to D−m−1 or less.
- R8: `almost_empty_n` changes only on read clock edges. It is 0 when the fill level is n or less (request mode) or n+1 or less (look-ahead mode), and 1 above that level.
- R9: If `ofs_load`=1 during reset, m and n are taken from `af_offset` and `ae_offset`. Otherwise they are taken from the parameters AF_OFS and AE_OFS.
- R10: The mode pin, `ofs_load` and the offset pins are sampled only while `rst_n` is low. Changing them after reset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Master reset, active low, sampled on both clocks |
| fwft_sel | input | 1 | Mode select sampled at reset: 0 request, 1 look-ahead |
| ofs_load | input | 1 | At reset, take offsets from pins instead of parameters |
| af_offset | input | ADDR_W+1 | Near-full offset m |
| ae_offset | input | ADDR_W+1 | Near-empty offset n |
| wr_valid | input | 1 | Write data valid |
| wr_ready | output | 1 | FIFO can accept a word |
| wr_data | input | DATA_W | Write data |
| rd_ready | input | 1 | Read request (request mode) or consume (look-ahead mode) |
| rd_valid | output | 1 | `rd_data` holds a word |
| rd_data | output | DATA_W | Read data |
| almost_full_n | output | 1 | Near-full flag, active low, write clock domain |
| almost_empty_n | output | 1 | Near-empty flag, active low, read clock domain |

## Verification
A corrupted pointer or a bad Gray crossing shows at the ports within one drain of the FIFO. The bench sees a word out of order, a drain that returns more or fewer than D words, or a flag that disagrees with the known fill level once both synchronizers have settled, which takes about four cycles of the slower clock. A wrong mode or offset capture shifts a flag edge by one or more words, or changes the depth, and the first fill after reset exposes it. A read or write that is not blocked at the boundary leaves an extra or missing word that the empty check after draining reports.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  typedef enum logic {MODE_REQ = 1'b0, MODE_LOOK = 1'b1} fifo_mode_e;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int RAM_D = 1 << ADDR_W;
  logic [DATA_W-1:0] cells [RAM_D];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
  import dcfifo_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int AF_OFS = 2,
  localparam int PW    = ADDR_W + 2,
  localparam int OW    = ADDR_W + 1
) (
  input  logic              wclk,
  input  logic              rst_n,
  input  logic              fwft_sel,
  input  logic              ld_en,
  input  logic [OW-1:0]     ld_af,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [PW-1:0]     rptr_g_s,
  input  logic [PW-1:0]     cons_g_s,
  output logic [PW-1:0]     wptr_g,
  output logic [ADDR_W-1:0] waddr,
  output logic              we,
  output logic              paf_n
);
  localparam int RAM_D = 1 << ADDR_W;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  fifo_mode_e    mode_w;
  logic [OW-1:0] af_ofs;
  logic [PW-1:0] wbin, rbin, cbin, ram_used, cnt, cnt_n, wbin_n, depth, af_thr;
  logic          full, push;

  always_comb begin
    rbin     = g2b(rptr_g_s);
    cbin     = g2b(cons_g_s);
    depth    = PW'(RAM_D) + ((mode_w == MODE_LOOK) ? PW'(1) : PW'(0));
    ram_used = wbin - rbin;
    cnt      = wbin - cbin;
    full     = (ram_used >= PW'(RAM_D)) || (cnt >= depth);
    push     = wr_valid && !full;
    wbin_n   = wbin + (push ? PW'(1) : PW'(0));
    cnt_n    = wbin_n - cbin;
    af_thr   = depth - PW'(af_ofs);
  end

  always_ff @(posedge wclk) begin
    if (!rst_n) begin
      mode_w <= fifo_mode_e'(fwft_sel);
      af_ofs <= ld_en ? ld_af : OW'(AF_OFS);
      wbin   <= '0;
      wptr_g <= '0;
      paf_n  <= 1'b1;
    end else begin
      wbin   <= wbin_n;
      wptr_g <= wbin_n ^ (wbin_n >> 1);
      paf_n  <= !(cnt_n >= af_thr);
    end
  end

  assign wr_ready = !full;
  assign we       = push;
  assign waddr    = wbin[ADDR_W-1:0];

  always_ff @(posedge wclk) begin
    if (rst_n) assert_no_overflow_R5: assert (ram_used <= PW'(RAM_D))
      else $error("write pointer ran past the read pointer");
  end

  assert_blocked_write_R5: assert property (@(posedge wclk) disable iff (!rst_n)
    !wr_ready |=> $stable(wptr_g));
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
  import dcfifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int AE_OFS = 2,
  localparam int PW    = ADDR_W + 2,
  localparam int OW    = ADDR_W + 1
) (
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              fwft_sel,
  input  logic              ld_en,
  input  logic [OW-1:0]     ld_ae,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic [PW-1:0]     wptr_g_s,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] raddr,
  output logic [PW-1:0]     rptr_g,
  output logic [PW-1:0]     cons_g,
  output logic              pae_n
);
  localparam int RAM_D = 1 << ADDR_W;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  fifo_mode_e        mode_r;
  logic [OW-1:0]     ae_ofs;
  logic [PW-1:0]     rbin, wbin_s, rbin_n, cons_n, cnt_n, ae_thr;
  logic              oval, oval_n, ram_has, fetch, look;
  logic [DATA_W-1:0] dout;

  always_comb begin
    look    = (mode_r == MODE_LOOK);
    wbin_s  = g2b(wptr_g_s);
    ram_has = (wbin_s != rbin);
    fetch   = ram_has && (look ? (!oval || rd_ready) : rd_ready);
    rbin_n  = rbin + (fetch ? PW'(1) : PW'(0));
    oval_n  = look ? (fetch || (oval && !rd_ready)) : fetch;
    cons_n  = rbin_n - ((look && oval_n) ? PW'(1) : PW'(0));
    cnt_n   = wbin_s - cons_n;
    ae_thr  = PW'(ae_ofs) + (look ? PW'(1) : PW'(0));
  end

  always_ff @(posedge rclk) begin
    if (!rst_n) begin
      mode_r <= fifo_mode_e'(fwft_sel);
      ae_ofs <= ld_en ? ld_ae : OW'(AE_OFS);
      rbin   <= '0;
      rptr_g <= '0;
      cons_g <= '0;
      oval   <= 1'b0;
      dout   <= '0;
      pae_n  <= 1'b0;
    end else begin
      rbin   <= rbin_n;
      rptr_g <= rbin_n ^ (rbin_n >> 1);
      cons_g <= cons_n ^ (cons_n >> 1);
      oval   <= oval_n;
      if (fetch) dout <= mem_rdata;
      pae_n  <= !(cnt_n <= ae_thr);
    end
  end

  assign raddr    = rbin[ADDR_W-1:0];
  assign rd_valid = oval;
  assign rd_data  = dout;

  always_ff @(posedge rclk) begin
    if (rst_n) assert_no_underflow_R6: assert ((wbin_s - rbin) <= PW'(RAM_D))
      else $error("read pointer ran past the write pointer");
  end

  assert_look_hold_R3: assert property (@(posedge rclk) disable iff (!rst_n)
    (look && oval && !rd_ready) |=> (oval && $stable(dout)));

  assert_req_no_spurious_R2: assert property (@(posedge rclk) disable iff (!rst_n)
    (!look && !rd_ready) |=> !oval);
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 4,
  parameter int AF_OFS      = 2,
  parameter int AE_OFS      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              fwft_sel,
  input  logic              ofs_load,
  input  logic [ADDR_W:0]   af_offset,
  input  logic [ADDR_W:0]   ae_offset,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              almost_full_n,
  output logic              almost_empty_n
);
  localparam int PW = ADDR_W + 2;

  logic [PW-1:0]     wptr_g, rptr_g, cons_g, wptr_g_s, rptr_g_s, cons_g_s;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              we;
  logic [DATA_W-1:0] mem_rdata;

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
    .clk(rclk), .rst_n(rst_n), .d(wptr_g), .q(wptr_g_s));
  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
    .clk(wclk), .rst_n(rst_n), .d(rptr_g), .q(rptr_g_s));
  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_c2w (
    .clk(wclk), .rst_n(rst_n), .d(cons_g), .q(cons_g_s));

  dcf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_rdata));

  dcf_wr_side #(.ADDR_W(ADDR_W), .AF_OFS(AF_OFS)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .fwft_sel(fwft_sel), .ld_en(ofs_load),
    .ld_af(af_offset), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rptr_g_s(rptr_g_s), .cons_g_s(cons_g_s), .wptr_g(wptr_g),
    .waddr(waddr), .we(we), .paf_n(almost_full_n));

  dcf_rd_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .AE_OFS(AE_OFS)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .fwft_sel(fwft_sel), .ld_en(ofs_load),
    .ld_ae(ae_offset), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .wptr_g_s(wptr_g_s), .mem_rdata(mem_rdata),
    .raddr(raddr), .rptr_g(rptr_g), .cons_g(cons_g), .pae_n(almost_empty_n));
endmodule

// File: tb/dcfifo_pflag_tb_top.sv
`timescale 1ns/1ps
module dcfifo_pflag_tb_top;
  localparam int DW = 16;
  localparam int AW = 3;
  localparam int RAM_D = 1 << AW;
  localparam int P_AF = 2;
  localparam int P_AE = 1;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic fwft_sel = 0, ofs_load = 0;
  logic [AW:0] af_offset = '0, ae_offset = '0;
  logic wr_valid = 0, rd_ready = 0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, rd_valid, almost_full_n, almost_empty_n;
  logic [DW-1:0] rd_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 wclk = ~wclk;
  always #13 rclk = ~rclk;

  dcfifo_pflag #(.DATA_W(DW), .ADDR_W(AW), .AF_OFS(P_AF), .AE_OFS(P_AE)) dut_i (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft_sel(fwft_sel),
    .ofs_load(ofs_load), .af_offset(af_offset), .ae_offset(ae_offset),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .almost_full_n(almost_full_n), .almost_empty_n(almost_empty_n));

  // row: {look, load, m, n}
  typedef struct packed { logic look; logic load; logic [3:0] m; logic [3:0] n; } row_t;
  localparam row_t ROWS [4] = '{
    '{1'b0, 1'b0, 4'd0, 4'd0},
    '{1'b1, 1'b0, 4'd0, 4'd0},
    '{1'b0, 1'b1, 4'd1, 4'd3},
    '{1'b1, 1'b1, 4'd3, 4'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(posedge wclk);
    repeat (5) @(posedge rclk);
    @(negedge wclk);
  endtask

  task automatic do_reset(input logic look, input logic ld, input logic [AW:0] m, input logic [AW:0] n);
    rst_n = 0; fwft_sel = look; ofs_load = ld; af_offset = m; ae_offset = n;
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);
    @(negedge wclk);
    chk("R1 reset wr_ready", wr_ready, 1);
    chk("R1 reset pae_n", almost_empty_n, 0);
    rst_n = 1;
    @(negedge wclk);
    // R10: pins changed after reset must not matter
    fwft_sel = ~look; ofs_load = ~ld; af_offset = 5; ae_offset = 5;
  endtask

  task automatic do_push(input logic [DW-1:0] d, output bit acc);
    @(negedge wclk);
    wr_data = d; wr_valid = 1; acc = wr_ready;
    @(posedge wclk); #1 wr_valid = 0;
  endtask

  task automatic do_read(input logic look, output bit v, output logic [DW-1:0] d);
    if (look) begin
      @(negedge rclk); v = rd_valid; d = rd_data; rd_ready = 1;
      @(posedge rclk); #1 rd_ready = 0;
    end else begin
      @(negedge rclk); rd_ready = 1;
      @(posedge rclk); #1 rd_ready = 0;
      @(negedge rclk); v = rd_valid; d = rd_data;
    end
  endtask

  task automatic check_flags(input int cnt, input int depth, input int m, input int n, input logic look);
    chk("R7 almost_full_n", almost_full_n, (cnt >= depth - m) ? 0 : 1);
    chk("R8 almost_empty_n", almost_empty_n, (cnt <= n + (look ? 1 : 0)) ? 0 : 1);
  endtask

  initial begin
    bit acc, v;
    logic [DW-1:0] d;
    int cnt, depth, m, n, sent, got;
    for (int r = 0; r < 4; r++) begin
      row_t row = ROWS[r];
      m = row.load ? int'(row.m) : P_AF;   // R9
      n = row.load ? int'(row.n) : P_AE;
      depth = RAM_D + (row.look ? 1 : 0);
      do_reset(row.look, row.load, AW'(row.m), AW'(row.n));
      settle();
      chk("R1 idle wr_ready", wr_ready, 1);
      chk("R1 idle rd_valid", rd_valid, 0);
      chk("R1 idle almost_full_n", almost_full_n, 1);
      chk("R1 idle almost_empty_n", almost_empty_n, 0);
      if (!row.look) begin
        do_read(1'b0, v, d);
        chk("R6 read while empty", v, 0);
        do_push(16'h0a00 + DW'(r), acc);
        settle();
        do_read(1'b0, v, d);
        chk("R6 next word after empty read", {15'd0, v, d}, {15'd0, 1'b1, 16'h0a00 + DW'(r)});
        settle();
      end
      cnt = 0; sent = 0;
      for (int i = 0; i < depth + 2; i++) begin
        do_push(DW'(r * 64 + i), acc);
        if (acc) begin cnt++; sent++; end
        settle();
        check_flags(cnt, depth, m, n, row.look);
        if (row.look) chk("R3 head presented", {15'd0, rd_valid, rd_data}, {15'd0, 1'b1, DW'(r * 64)});
      end
      chk("R4 depth accepted", cnt, depth);
      chk("R4 wr_ready low when full", wr_ready, 0);
      do_push(16'hdead, acc);
      chk("R5 write while full refused", acc, 0);
      settle();
      if (row.look) begin
        @(negedge rclk);
        d = rd_data;
        repeat (3) @(posedge rclk);
        @(negedge rclk);
        chk("R3 held without rd_ready", rd_data, d);
      end
      got = 0;
      for (int i = 0; i < depth; i++) begin
        do_read(row.look, v, d);
        chk(row.look ? "R3 order" : "R2 order", {15'd0, v, d}, {15'd0, 1'b1, DW'(r * 64 + i)});
        cnt--; got++;
        settle();
        check_flags(cnt, depth, m, n, row.look);
      end
      chk("R5 drained count", got, sent);
      do_read(row.look, v, d);
      chk("R5 R6 empty after drain", v, 0);
      settle();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule